// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers 31 level-sensitive interrupt requests from on-chip peripherals and turns them into one external-interrupt request for the CPU. Each request line has a 3-bit priority code that software writes. Codes 0 to 6 are live levels, with 0 as the most urgent. Code 7 turns the source off. Each clock, a comparison tree picks the enabled pending source with the smallest level code. When two sources share that code, the lower source index wins. The winner's index and level are registered and driven out. The request line is raised only while the winning level is numerically below a programmable mask level.

A second path watches an active-low break pin, which is independent of the maskable sources. The pin passes through a two-stage synchroniser into a small state machine with three states:

- BRK_WAIT_HIGH: the pin must be seen high before an edge is accepted.
- BRK_ARMED: a synchronised low level counts as a falling edge.
- BRK_PENDING: the sticky break request is held.

The transitions are named as follows:

- *arm*: BRK_WAIT_HIGH to BRK_ARMED, when the synchronised pin is high.
- *trigger*: BRK_ARMED to BRK_PENDING, when the synchronised pin is low.
- *clear-high*: BRK_PENDING to BRK_ARMED, on the clear strobe while the pin is high.
- *clear-low*: BRK_PENDING to BRK_WAIT_HIGH, on the clear strobe while the pin is low.

No mask level and no CPU enable flag can hold the break request back.

Software reaches a small register space through a write strobe, an address and write data:

- Addresses 0 to 30 hold the per-source level codes.
- Address 31 holds the mask level.

The read data port returns the addressed register without waiting for a clock.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During and after reset every source level reads 7, the mask reads 0, ei_req and brk_req are 0, ei_src is 31 and ei_lvl is 7.
- R2: A write with reg_wr high stores reg_wdata into source level reg_addr (0..30) or into the mask (address 31) at the clock edge, and reg_rdata returns the register at reg_addr combinationally.
- R3: A source whose level code is 7 is never selected, even if it is the only request; with no enabled pending source ei_src shows 31, ei_lvl shows 7 and ei_req is 0.
- R4: Among enabled pending sources, the one with the numerically smallest level code is selected.
- R5: Among enabled pending sources sharing the smallest level code, the lowest source index is selected.
- R6: ei_req is 1 only when the selected level is numerically below the mask; ei_src and ei_lvl show the selected source even when ei_req is 0.
- R7: The outputs are registered: a change on irq_req appears on the outputs after the next rising edge, and a register write takes effect on the outputs one rising edge after the write edge.
- R8: A high-to-low change on brk_pin_n (after the pin was seen high) sets brk_req after the third rising edge following the change, independent of the mask and of ei_req.
- R9: brk_req stays 1 whatever the pin does until brk_clr is sampled high, after which it is 0 following that edge.
- R10: A pin that is low at reset release, or low when the break is cleared, raises no break until it has been seen high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 31 | Level-sensitive request per peripheral source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: 0..30 source levels, 31 mask |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data at reg_addr |
| brk_pin_n | input | 1 | Asynchronous break pin, falling edge triggers |
| brk_clr | input | 1 | Strobe that clears a pending break |
| ei_req | output | 1 | External-interrupt request to the CPU |
| ei_src | output | 5 | Selected source index, 31 when none |
| ei_lvl | output | 3 | Selected level, 7 when none |
| brk_req | output | 1 | Sticky unmaskable break request |

## Verification
The assertions take for granted that irq_req, the register port and brk_clr are driven away from the clock edge. They also take for granted that these inputs hold known values from time zero. The bench drives every input at the falling edge and initialises all of them before reset is released.

The break assertions assume the clear strobe is a plain synchronous input. They place no rule on how fast the pin toggles, because the synchroniser absorbs that. The stimulus holds each pin level for several cycles so that every transition of the state machine is crossed on purpose.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    // Default source count and level width of the controller
    localparam int unsigned SRC_COUNT  = 31;
    localparam int unsigned LEVEL_BITS = 3;

    // Break detector states
    typedef enum logic [1:0] {
        BRK_WAIT_HIGH = 2'd0,
        BRK_ARMED     = 2'd1,
        BRK_PENDING   = 2'd2
    } brk_state_e;

endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs #(
    parameter int unsigned N_SRC  = prio_irq_pkg::SRC_COUNT,
    parameter int unsigned LVL_W  = prio_irq_pkg::LEVEL_BITS,
    parameter int unsigned ADDR_W = $clog2(N_SRC + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [LVL_W-1:0]            wr_data,
    output logic [LVL_W-1:0]            rd_data,
    output logic [N_SRC-1:0][LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0]            mask_q
);

    localparam logic [LVL_W-1:0]  LVL_OFF   = '1;
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(N_SRC);

    // Per-source level codes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_SRC); i++) begin
                lvl_q[i] <= LVL_OFF;
            end
        end else if (wr_en) begin
            for (int i = 0; i < int'(N_SRC); i++) begin
                if (addr == ADDR_W'(i)) begin
                    lvl_q[i] <= wr_data;
                end
            end
        end
    end

    // Current mask level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && addr == MASK_ADDR) begin
            mask_q <= wr_data;
        end
    end

    // Combinational read-back
    always_comb begin
        rd_data = '0;
        if (addr == MASK_ADDR) begin
            rd_data = mask_q;
        end else begin
            for (int i = 0; i < int'(N_SRC); i++) begin
                if (addr == ADDR_W'(i)) begin
                    rd_data = lvl_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int unsigned N_SRC = prio_irq_pkg::SRC_COUNT,
    parameter int unsigned LVL_W = prio_irq_pkg::LEVEL_BITS,
    parameter int unsigned IDX_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]            req,
    input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx,
    output logic [LVL_W-1:0]            win_lvl
);

    localparam int unsigned      LEAVES  = 2 ** IDX_W;
    localparam int unsigned      NODES   = 2 * LEAVES - 1;
    localparam logic [LVL_W-1:0] LVL_OFF = '1;

    // Heap-ordered tree: node n has children 2n+1 and 2n+2.
    // Leaf k lives at LEAVES-1+k, so left subtrees hold lower indices.
    logic             nd_v [NODES];
    logic [LVL_W-1:0] nd_l [NODES];
    logic [IDX_W-1:0] nd_i [NODES];

    // Leaves: a source takes part only when pending and not disabled
    for (genvar k = 0; k < int'(LEAVES); k++) begin : g_leaf
        if (k < int'(N_SRC)) begin : g_real
            assign nd_v[LEAVES-1+k] = req[k] && (lvl[k] != LVL_OFF);
            assign nd_l[LEAVES-1+k] = lvl[k];
        end else begin : g_pad
            assign nd_v[LEAVES-1+k] = 1'b0;
            assign nd_l[LEAVES-1+k] = LVL_OFF;
        end
        assign nd_i[LEAVES-1+k] = IDX_W'(k);
    end

    // Internal nodes: right child wins only on a strictly smaller level
    always_comb begin
        for (int n = int'(LEAVES) - 2; n >= 0; n--) begin
            if (nd_v[2*n+2] && (!nd_v[2*n+1] || nd_l[2*n+2] < nd_l[2*n+1])) begin
                nd_v[n] = 1'b1;
                nd_l[n] = nd_l[2*n+2];
                nd_i[n] = nd_i[2*n+2];
            end else begin
                nd_v[n] = nd_v[2*n+1];
                nd_l[n] = nd_l[2*n+1];
                nd_i[n] = nd_i[2*n+1];
            end
        end
    end

    assign win_valid = nd_v[0];
    assign win_idx   = nd_i[0];
    assign win_lvl   = nd_l[0];

endmodule

// File: rtl/brk_detect.sv
module brk_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic clr,
    output logic brk_req
);

    import prio_irq_pkg::*;

    logic       pin_s1;
    logic       pin_s2;
    brk_state_e state;
    brk_state_e state_nx;

    // Two-stage synchroniser, reset low so a low pin cannot fake a fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_s1 <= 1'b0;
            pin_s2 <= 1'b0;
        end else begin
            pin_s1 <= pin_n;
            pin_s2 <= pin_s1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BRK_WAIT_HIGH;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: arm, trigger, clear-high, clear-low
    always_comb begin
        state_nx = state;
        unique case (state)
            BRK_WAIT_HIGH: if (pin_s2)  state_nx = BRK_ARMED;
            BRK_ARMED:     if (!pin_s2) state_nx = BRK_PENDING;
            BRK_PENDING:   if (clr)     state_nx = pin_s2 ? BRK_ARMED : BRK_WAIT_HIGH;
            default:                    state_nx = BRK_WAIT_HIGH;
        endcase
    end

    // Output decode
    always_comb begin
        brk_req = (state == BRK_PENDING);
    end

    // R9: a pending break survives until cleared
    p_brk_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !clr) |=> brk_req);

    // R9: a clear of a pending break drops it
    p_brk_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && clr) |=> !brk_req);

    // R10: while waiting for a high pin no break can appear
    p_wait_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BRK_WAIT_HIGH) |=> !brk_req);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int unsigned N_SRC  = prio_irq_pkg::SRC_COUNT,
    parameter int unsigned LVL_W  = prio_irq_pkg::LEVEL_BITS,
    parameter int unsigned ADDR_W = $clog2(N_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LVL_W-1:0]  reg_wdata,
    output logic [LVL_W-1:0]  reg_rdata,
    input  logic              brk_pin_n,
    input  logic              brk_clr,
    output logic              ei_req,
    output logic [ADDR_W-1:0] ei_src,
    output logic [LVL_W-1:0]  ei_lvl,
    output logic              brk_req
);

    localparam logic [LVL_W-1:0]  LVL_OFF  = '1;
    localparam logic [ADDR_W-1:0] SRC_NONE = ADDR_W'(N_SRC);

    logic [N_SRC-1:0][LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0]            mask_q;
    logic                        win_valid;
    logic [ADDR_W-1:0]           win_idx;
    logic [LVL_W-1:0]            win_lvl;

    irq_level_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .lvl_q   (lvl_q),
        .mask_q  (mask_q)
    );

    irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(ADDR_W)) u_arb (
        .req       (irq_req),
        .lvl       (lvl_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    brk_detect u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (brk_pin_n),
        .clr     (brk_clr),
        .brk_req (brk_req)
    );

    // Registered arbitration result and mask compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ei_req <= 1'b0;
            ei_src <= SRC_NONE;
            ei_lvl <= LVL_OFF;
        end else begin
            ei_req <= win_valid && (win_lvl < mask_q);
            ei_src <= win_valid ? win_idx : SRC_NONE;
            ei_lvl <= win_valid ? win_lvl : LVL_OFF;
        end
    end

    // R3: the tree only reports a pending, enabled source
    p_win_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (irq_req[win_idx] && lvl_q[win_idx] != LVL_OFF));

    // R6: a raised request always beats the mask in force at the prior edge
    p_ei_below_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ei_req |-> (ei_lvl < $past(mask_q)));

    for (genvar g = 0; g < int'(N_SRC); g++) begin : g_chk
        // R4: no enabled pending source beats the winner
        p_win_not_worse_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[g] && lvl_q[g] != LVL_OFF) |-> (win_valid && win_lvl <= lvl_q[g]));
        // R5: on a tie the winner has the smaller index
        p_tie_low_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && irq_req[g] && lvl_q[g] == win_lvl) |-> (win_idx <= ADDR_W'(g)));
    end

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] irq_req = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [2:0]  reg_wdata = '0;
    logic [2:0]  reg_rdata;
    logic        brk_pin_n = 1'b0;
    logic        brk_clr = 1'b0;
    logic        ei_req;
    logic [4:0]  ei_src;
    logic [2:0]  ei_lvl;
    logic        brk_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .brk_pin_n (brk_pin_n),
        .brk_clr   (brk_clr),
        .ei_req    (ei_req),
        .ei_src    (ei_src),
        .ei_lvl    (ei_lvl),
        .brk_req   (brk_req)
    );

    // Vector: {req tag 4b, irq_req 31b, ei_req 1b, ei_src 5b, ei_lvl 3b}
    // Levels programmed as index mod 8, mask 5.
    localparam logic [43:0] VEC [12] = '{
        {4'd3, 31'h0000_0000, 1'b0, 5'd31, 3'd7},
        {4'd3, 31'h0000_0080, 1'b0, 5'd31, 3'd7},
        {4'd4, 31'h0000_0008, 1'b1, 5'd3,  3'd3},
        {4'd5, 31'h0000_0808, 1'b1, 5'd3,  3'd3},
        {4'd5, 31'h0008_0800, 1'b1, 5'd11, 3'd3},
        {4'd6, 31'h0000_0040, 1'b0, 5'd6,  3'd6},
        {4'd6, 31'h0000_2040, 1'b0, 5'd13, 3'd5},
        {4'd4, 31'h0000_2010, 1'b1, 5'd4,  3'd4},
        {4'd4, 31'h4000_0100, 1'b1, 5'd8,  3'd0},
        {4'd5, 31'h7FFF_FFFF, 1'b1, 5'd0,  3'd0},
        {4'd3, 31'h0080_8080, 1'b0, 5'd31, 3'd7},
        {4'd5, 31'h4101_0000, 1'b1, 5'd16, 3'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [2:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [4:0] a, input int exp);
        reg_addr = a;
        #1;
        check(tag, int'(reg_rdata), exp);
    endtask

    task automatic clear_brk();
        brk_clr = 1'b1;
        tick(1);
        brk_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Reset with the break pin low
        tick(3);
        check("R1 ei_req in reset", int'(ei_req), 0);
        check("R1 ei_src in reset", int'(ei_src), 31);
        check("R1 ei_lvl in reset", int'(ei_lvl), 7);
        check("R1 brk_req in reset", int'(brk_req), 0);
        rd_check("R1 level 0 reset value", 5'd0, 7);
        rd_check("R1 mask reset value", 5'd31, 0);
        rst_n = 1'b1;
        tick(5);
        check("R10 low pin at reset release", int'(brk_req), 0);
        check("R1 ei_req after reset", int'(ei_req), 0);

        // Break path: arm, then trigger
        brk_pin_n = 1'b1;
        tick(4);
        check("R8 no break while high", int'(brk_req), 0);
        brk_pin_n = 1'b0;
        tick(2);
        check("R8 no break two edges after fall", int'(brk_req), 0);
        tick(1);
        check("R8 break on third edge", int'(brk_req), 1);
        check("R8 break independent of ei_req", int'(ei_req), 0);
        brk_pin_n = 1'b1;
        tick(5);
        check("R9 break sticky after pin high", int'(brk_req), 1);
        clear_brk();
        check("R9 clear drops break", int'(brk_req), 0);
        brk_pin_n = 1'b0;
        tick(3);
        check("R8 re-armed break", int'(brk_req), 1);
        clear_brk();
        check("R9 clear while pin low", int'(brk_req), 0);
        tick(5);
        check("R10 held low pin after clear", int'(brk_req), 0);
        brk_pin_n = 1'b1;
        tick(4);
        brk_pin_n = 1'b0;
        tick(3);
        check("R10 break after high then low", int'(brk_req), 1);
        clear_brk();

        // Program levels index mod 8 and mask 5
        for (int i = 0; i < 31; i++) begin
            wr(5'(i), 3'(i % 8));
        end
        wr(5'd31, 3'd5);
        rd_check("R2 level 13 read-back", 5'd13, 5);
        rd_check("R2 mask read-back", 5'd31, 5);

        // Vector table
        for (int v = 0; v < 12; v++) begin
            irq_req = VEC[v][39:9];
            tick(1);
            check($sformatf("R%0d vec%0d ei_req", VEC[v][43:40], v), int'(ei_req), int'(VEC[v][8]));
            check($sformatf("R%0d vec%0d ei_src", VEC[v][43:40], v), int'(ei_src), int'(VEC[v][7:3]));
            check($sformatf("R%0d vec%0d ei_lvl", VEC[v][43:40], v), int'(ei_lvl), int'(VEC[v][2:0]));
        end

        // Mask write latency
        irq_req = 31'h0000_0040;
        tick(1);
        check("R6 level 6 under mask 5", int'(ei_req), 0);
        wr(5'd31, 3'd7);
        check("R7 mask not yet applied", int'(ei_req), 0);
        tick(1);
        check("R7 mask applied one edge later", int'(ei_req), 1);

        // Mask 0 blocks even level 0
        irq_req = 31'h0000_0100;
        tick(1);
        check("R4 level 0 source with mask 7", int'(ei_src), 8);
        wr(5'd31, 3'd0);
        tick(1);
        check("R6 mask 0 blocks request", int'(ei_req), 0);
        check("R6 source shown while masked", int'(ei_src), 8);
        check("R6 level shown while masked", int'(ei_lvl), 0);

        // Level rewrite changes the winner
        wr(5'd31, 3'd7);
        irq_req = 31'h0000_0808;
        tick(1);
        check("R5 tie before rewrite", int'(ei_src), 3);
        wr(5'd11, 3'd1);
        tick(1);
        check("R4 rewritten level wins", int'(ei_src), 11);
        check("R4 rewritten level value", int'(ei_lvl), 1);
        check("R4 request raised", int'(ei_req), 1);
        rd_check("R2 rewritten level read-back", 5'd11, 1);

        // Disabled source alone
        wr(5'd3, 3'd7);
        irq_req = 31'h0000_0008;
        tick(1);
        check("R3 lone disabled source ei_req", int'(ei_req), 0);
        check("R3 lone disabled source ei_src", int'(ei_src), 31);
        check("R3 lone disabled source ei_lvl", int'(ei_lvl), 7);

        // Request removal, one edge latency
        irq_req = 31'h0000_0800;
        tick(1);
        check("R7 new request after one edge", int'(ei_src), 11);
        irq_req = '0;
        tick(1);
        check("R7 release after one edge", int'(ei_req), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule